// File: doc/BRIEF.md
# Tagged Fully-Associative Address Translation Cache

This block caches virtual-to-physical page translations for a load/store pipeline. Any of its 32 slots can hold any translation. Each slot is tagged with a virtual-machine identifier, an address-space identifier and a global flag, so the cache can keep translations from several processes and several guests at once. It also records the page granule, 4KB or 64KB, that was in force when the slot was written. A lookup compares the virtual address against all slots at once. The hit flag, the physical address and the stored attribute byte come back combinationally in the same cycle.

An external table walker writes new translations through a fill stream that uses valid/ready. A fill transfers on a clock edge where both `fill_valid` and `fill_ready` are high. The walker keeps its payload stable while it waits. `fill_ready` depends only on `inv_valid`, never on `fill_valid`. It drops for exactly the cycles in which an invalidate command is present. The lookup port has no back-pressure: `lk_valid` qualifies the request, and the result belongs to that same cycle.

An invalidate command takes one cycle. It can clear every slot, the non-global slots of one ASID, or every slot of one VMID. State changes from a fill or an invalidate are visible to lookups from the next cycle on.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no slot is valid: every lookup misses, `lk_pa` and `lk_attr` read zero, and `fill_ready` is high while `inv_valid` is low.
- R2: A lookup hits a slot only if all four of these hold. The slot is valid. Its VMID equals `lk_vmid`. Its recorded granule equals `cfg_gran64` (0 = 4KB, 1 = 64KB). Its tag equals the VA: bits [47:12] for a 4KB slot, bits [47:16] for a 64KB slot.
- R3: On a slot whose global flag is set, the ASID plays no part in matching. On a slot whose global flag is clear, the stored ASID must equal `lk_asid`.
- R4: With `cfg_asid16` = 0, only ASID bits [7:0] are compared, for lookups and for ASID invalidation. With `cfg_asid16` = 1, all 16 bits are compared.
- R5: On a hit, `lk_pa` depends on the slot's granule. For a 4KB slot it is {stored PA[43:12], VA[11:0]}. For a 64KB slot it is {stored PA[43:16], VA[15:0]}. `lk_attr` is the stored attribute byte. On a miss, both `lk_pa` and `lk_attr` are zero.
- R6: An accepted fill writes the lowest-indexed invalid slot when one exists, and no valid slot is disturbed.
- R7: When every slot is valid, a fill replaces the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo 32, on every accepted fill.
- R8: When several slots match a lookup, the lowest-indexed one supplies `lk_pa` and `lk_attr`.
- R9: Invalidate code 0 clears all slots in one cycle.
- R10: Invalidate code 1 clears only the non-global slots whose ASID matches `inv_asid` (width per R4). Code 2 clears every slot whose VMID equals `inv_vmid`. Code 3 changes nothing.
- R11: While `inv_valid` is high, `fill_ready` is low and no fill is written. A lookup in the same cycle as an invalidate or a fill still sees the state from before that cycle.
- R12: `lk_hit` is low whenever `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_asid16 | input | 1 | 1 = 16-bit ASID compare, 0 = 8-bit |
| cfg_gran64 | input | 1 | Current granule: 1 = 64KB, 0 = 4KB; recorded on fill, matched on lookup |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current ASID |
| lk_vmid | input | 8 | Current VMID |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 44 | Translated physical address |
| lk_attr | output | 8 | Attribute byte of the hitting slot |
| fill_valid | input | 1 | Fill payload present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_va | input | 48 | Virtual address of the new translation |
| fill_asid | input | 16 | ASID of the new translation |
| fill_vmid | input | 8 | VMID of the new translation |
| fill_global | input | 1 | Global flag of the new translation |
| fill_pa | input | 44 | Physical page address of the new translation |
| fill_attr | input | 8 | Attribute byte of the new translation |
| inv_valid | input | 1 | Invalidate command present |
| inv_op | input | 2 | 0 all, 1 by ASID, 2 by VMID, 3 none |
| inv_asid | input | 16 | ASID operand of code 1 |
| inv_vmid | input | 8 | VMID operand of code 2 |

## Verification
A wrong valid bit shows up at the first lookup aimed at that slot. A stale translation reads as an unexpected hit, and a lost one reads as a miss, with no delay beyond that lookup. An error in the victim choice or in the replacement pointer stays hidden until the cache is full. It then shows on the following lookups, either as a wrong translation surviving or as a live translation being evicted. A faulty priority between matching slots, or faulty offset merging, corrupts `lk_pa` in the same cycle as the request. A reference model updated on every edge therefore exposes any of these at the first lookup that touches the damaged slot.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    INV_ALL     = 2'd0,
    INV_BY_ASID = 2'd1,
    INV_BY_VMID = 2'd2,
    INV_NOP     = 2'd3
  } inv_kind_e;

  localparam int unsigned SMALL_PAGE_LSB = 12;
  localparam int unsigned LARGE_PAGE_LSB = 16;
  localparam int unsigned NARROW_ASID_W  = 8;
endpackage

// File: rtl/xlat_entry_cmp.sv
module xlat_entry_cmp #(
  parameter int VPN_W     = 36,
  parameter int ASID_W    = 16,
  parameter int VMID_W    = 8,
  parameter int GRAN_SKIP = 4,
  parameter int ASID_LO   = 8
) (
  input  logic              e_valid,
  input  logic              e_global,
  input  logic              e_gran64,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VMID_W-1:0] q_vmid,
  input  logic              cfg_asid16,
  input  logic              cfg_gran64,
  input  logic [ASID_W-1:0] k_asid,
  input  logic [VMID_W-1:0] k_vmid,
  output logic              lk_match,
  output logic              kill_asid,
  output logic              kill_vmid
);
  localparam logic [VPN_W-1:0]  SMALL_MASK = '1;
  localparam logic [VPN_W-1:0]  LARGE_MASK = {{(VPN_W-GRAN_SKIP){1'b1}}, {GRAN_SKIP{1'b0}}};
  localparam logic [ASID_W-1:0] WIDE_MASK  = '1;
  localparam logic [ASID_W-1:0] NARROW_MASK = {{(ASID_W-ASID_LO){1'b0}}, {ASID_LO{1'b1}}};

  logic [VPN_W-1:0]  vmask;
  logic [ASID_W-1:0] amask;
  logic              tag_eq;
  logic              asid_ok;
  logic              vmid_eq;

  always_comb begin
    // the page size of the slot decides how many tag bits count
    vmask    = e_gran64 ? LARGE_MASK : SMALL_MASK;
    amask    = cfg_asid16 ? WIDE_MASK : NARROW_MASK;
    tag_eq   = ((e_vpn ^ q_vpn) & vmask) == '0;
    asid_ok  = e_global || (((e_asid ^ q_asid) & amask) == '0);
    vmid_eq  = (e_vmid == q_vmid);
    lk_match = e_valid && tag_eq && asid_ok && vmid_eq && (e_gran64 == cfg_gran64);
    kill_asid = e_valid && !e_global && (((e_asid ^ k_asid) & amask) == '0);
    kill_vmid = e_valid && (e_vmid == k_vmid);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_i,
  input  logic [IW-1:0] rr_i,
  output logic [IW-1:0] slot_o,
  output logic          free_o
);
  always_comb begin
    free_o = 1'b0;
    slot_o = rr_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_o = 1'b1;
        slot_o = IW'(i);
      end
    end
  end

  // R6: a free slot chosen here must really be empty and have no empty slot below it
  always_comb begin
    if (free_o) begin
      a_r6_free_slot_empty: assert (!valid_i[slot_o]);
      a_r6_lowest_free: assert ((~valid_i & ~({N{1'b1}} << slot_o)) == '0);
    end
  end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_vec,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R8: the winner matches and no lower slot matches
  always_comb begin
    if (any_o) begin
      a_r8_winner_matches: assert (hit_vec[idx_o]);
      a_r8_lowest_wins: assert ((hit_vec & ~({N{1'b1}} << idx_o)) == '0);
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 48,
  parameter int PA_W    = 44,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 8,
  parameter int ATTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_asid16,
  input  logic              cfg_gran64,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic              fill_global,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VMID_W-1:0] inv_vmid
);
  import xlat_pkg::*;

  localparam int PG     = SMALL_PAGE_LSB;
  localparam int BIG    = LARGE_PAGE_LSB;
  localparam int SKIP   = BIG - PG;
  localparam int VPN_W  = VA_W - PG;
  localparam int PPN_W  = PA_W - PG;
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  // slot state
  logic [ENTRIES-1:0] v_q;
  logic [ENTRIES-1:0] g_q;
  logic [ENTRIES-1:0] big_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VMID_W-1:0]  vmid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] kill_a;
  logic [ENTRIES-1:0] kill_v;
  logic [ENTRIES-1:0] kill;
  logic               any_hit;
  logic [IW-1:0]      sel;
  logic [IW-1:0]      victim;
  logic               victim_free;
  logic               fill_fire;
  inv_kind_e          op;
  logic               unused_low_bits;

  assign unused_low_bits = ^{fill_va[PG-1:0], fill_pa[PG-1:0], victim_free};

  // one comparator per slot
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    xlat_entry_cmp #(
      .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W),
      .GRAN_SKIP(SKIP), .ASID_LO(NARROW_ASID_W)
    ) u_cmp (
      .e_valid   (v_q[e]),
      .e_global  (g_q[e]),
      .e_gran64  (big_q[e]),
      .e_asid    (asid_q[e]),
      .e_vmid    (vmid_q[e]),
      .e_vpn     (vpn_q[e]),
      .q_vpn     (lk_va[VA_W-1:PG]),
      .q_asid    (lk_asid),
      .q_vmid    (lk_vmid),
      .cfg_asid16(cfg_asid16),
      .cfg_gran64(cfg_gran64),
      .k_asid    (inv_asid),
      .k_vmid    (inv_vmid),
      .lk_match  (hit_vec[e]),
      .kill_asid (kill_a[e]),
      .kill_vmid (kill_v[e])
    );
  end

  xlat_pick #(.N(ENTRIES), .IW(IW)) u_pick (
    .hit_vec(hit_vec),
    .any_o  (any_hit),
    .idx_o  (sel)
  );

  xlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .valid_i(v_q),
    .rr_i   (rr_q),
    .slot_o (victim),
    .free_o (victim_free)
  );

  // invalidate wins over fill: the fill stream stalls in that cycle
  assign fill_ready = !inv_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign op         = inv_kind_e'(inv_op);

  always_comb begin
    kill = '0;
    if (inv_valid) begin
      case (op)
        INV_ALL:     kill = '1;
        INV_BY_ASID: kill = kill_a;
        INV_BY_VMID: kill = kill_v;
        default:     kill = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else begin
      v_q <= v_q & ~kill;
      if (fill_fire) begin
        v_q[victim] <= 1'b1;
        rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end

  // payload needs no reset: it is only read behind a valid bit
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      g_q[victim]    <= fill_global;
      big_q[victim]  <= cfg_gran64;
      asid_q[victim] <= fill_asid;
      vmid_q[victim] <= fill_vmid;
      vpn_q[victim]  <= fill_va[VA_W-1:PG];
      ppn_q[victim]  <= fill_pa[PA_W-1:PG];
      attr_q[victim] <= fill_attr;
    end
  end

  // result merge: offset width follows the hitting slot's granule
  always_comb begin
    lk_hit  = lk_valid && any_hit;
    lk_pa   = '0;
    lk_attr = '0;
    if (lk_hit) begin
      lk_attr = attr_q[sel];
      if (big_q[sel]) lk_pa = {ppn_q[sel][PPN_W-1:SKIP], lk_va[BIG-1:0]};
      else            lk_pa = {ppn_q[sel], lk_va[PG-1:0]};
    end
  end

  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 2'd0) |=> (v_q == '0));

  a_r10_nop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 2'd3) |=> (v_q == $past(v_q)));

  a_r11_no_growth_on_inv: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> ($countones(v_q) <= $countones($past(v_q))));

  a_r6_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (v_q != '0));

  a_r7_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (rr_q != $past(rr_q)));

  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready) |=> $stable(rr_q));

  a_r12_hit_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && v_q != '0));
endmodule

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_asid16 = 1'b1, cfg_gran64 = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_va = '0;
  logic [15:0] lk_asid = '0;
  logic [7:0]  lk_vmid = '0;
  logic        lk_hit;
  logic [43:0] lk_pa;
  logic [7:0]  lk_attr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [47:0] fill_va = '0;
  logic [15:0] fill_asid = '0;
  logic [7:0]  fill_vmid = '0;
  logic        fill_global = 1'b0;
  logic [43:0] fill_pa = '0;
  logic [7:0]  fill_attr = '0;
  logic        inv_valid = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [15:0] inv_asid = '0;
  logic [7:0]  inv_vmid = '0;

  int n_run = 0, n_fail = 0;
  logic hand_en = 1'b0, hand_hit = 1'b0;

  // reference model
  logic        mv [N];
  logic        mg [N];
  logic        mbig [N];
  logic [15:0] ma [N];
  logic [7:0]  mvm [N];
  logic [47:0] mva [N];
  logic [43:0] mpa [N];
  logic [7:0]  mat [N];
  int          mptr = 0;

  xlat_tlb dut (
    .clk(clk), .rst_n(rst_n), .cfg_asid16(cfg_asid16), .cfg_gran64(cfg_gran64),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_va(fill_va),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_global(fill_global),
    .fill_pa(fill_pa), .fill_attr(fill_attr),
    .inv_valid(inv_valid), .inv_op(inv_op), .inv_asid(inv_asid), .inv_vmid(inv_vmid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic asid_eq(input logic [15:0] a, input logic [15:0] b);
    return cfg_asid16 ? (a == b) : (a[7:0] == b[7:0]);
  endfunction

  task automatic model_look(output logic h, output logic [43:0] pa, output logic [7:0] at);
    h = 1'b0; pa = '0; at = '0;
    if (lk_valid) begin
      for (int i = 0; i < N; i++) begin
        if (!h && mv[i] && mvm[i] == lk_vmid && mbig[i] == cfg_gran64 &&
            (mg[i] || asid_eq(ma[i], lk_asid)) &&
            (mbig[i] ? (mva[i][47:16] == lk_va[47:16]) : (mva[i][47:12] == lk_va[47:12]))) begin
          h  = 1'b1;
          at = mat[i];
          pa = mbig[i] ? {mpa[i][43:16], lk_va[15:0]} : {mpa[i][43:12], lk_va[11:0]};
        end
      end
    end
  endtask

  task automatic model_edge();
    int slot;
    if (inv_valid) begin
      for (int i = 0; i < N; i++) begin
        case (inv_op)
          2'd0: mv[i] = 1'b0;
          2'd1: if (!mg[i] && asid_eq(ma[i], inv_asid)) mv[i] = 1'b0;
          2'd2: if (mvm[i] == inv_vmid) mv[i] = 1'b0;
          default: ;
        endcase
      end
    end else if (fill_valid) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (slot < 0 && !mv[i]) slot = i;
      if (slot < 0) slot = mptr;
      mv[slot] = 1'b1; mg[slot] = fill_global; mbig[slot] = cfg_gran64;
      ma[slot] = fill_asid; mvm[slot] = fill_vmid; mva[slot] = fill_va;
      mpa[slot] = fill_pa; mat[slot] = fill_attr;
      mptr = (mptr + 1) % N;
    end
  endtask

  // one clock: compare at the falling edge, advance the model at the rising edge
  task automatic cycle(input string tag);
    logic eh; logic [43:0] ep; logic [7:0] ea;
    @(negedge clk);
    model_look(eh, ep, ea);
    chk(tag, "lk_hit", 64'(lk_hit), 64'(eh));
    chk(tag, "lk_pa", 64'(lk_pa), 64'(ep));
    chk(tag, "lk_attr", 64'(lk_attr), 64'(ea));
    chk(tag, "fill_ready", 64'(fill_ready), 64'(!inv_valid));
    if (hand_en) chk(tag, "lk_hit(hand)", 64'(lk_hit), 64'(hand_hit));
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic look(input logic [47:0] va, input logic [15:0] asid, input logic [7:0] vmid,
                      input logic exp_hit, input string tag);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_vmid = vmid;
    hand_en = 1'b1; hand_hit = exp_hit;
    cycle(tag);
    hand_en = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [47:0] va, input logic [15:0] asid, input logic [7:0] vmid,
                      input logic g, input logic [43:0] pa, input logic [7:0] at, input string tag);
    fill_valid = 1'b1; fill_va = va; fill_asid = asid; fill_vmid = vmid;
    fill_global = g; fill_pa = pa; fill_attr = at;
    cycle(tag);
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic [1:0] code, input logic [15:0] asid, input logic [7:0] vmid,
                       input string tag);
    inv_valid = 1'b1; inv_op = code; inv_asid = asid; inv_vmid = vmid;
    cycle(tag);
    inv_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look(48'h1234_5678_9abc, 16'h5, 8'h1, 1'b0, "R1");

    // R2/R5 basic 4KB translation
    fill(48'h1234_5678_9000, 16'h0105, 8'h01, 1'b0, 44'habc_def0_1000, 8'h5a, "R5");
    look(48'h1234_5678_9abc, 16'h0105, 8'h01, 1'b1, "R5");
    look(48'h1234_5678_9001, 16'h0105, 8'h01, 1'b1, "R5");
    look(48'h1234_5678_a000, 16'h0105, 8'h01, 1'b0, "R2");
    look(48'h1234_5678_9abc, 16'h0105, 8'h02, 1'b0, "R2");
    // R3: non-global needs ASID
    look(48'h1234_5678_9abc, 16'h0106, 8'h01, 1'b0, "R3");
    // R4: upper ASID byte ignored in narrow mode
    look(48'h1234_5678_9abc, 16'h7705, 8'h01, 1'b0, "R4");
    cfg_asid16 = 1'b0;
    look(48'h1234_5678_9abc, 16'h7705, 8'h01, 1'b1, "R4");
    cfg_asid16 = 1'b1;
    // R12: no request, no hit
    lk_va = 48'h1234_5678_9abc; lk_asid = 16'h0105; lk_vmid = 8'h01;
    hand_en = 1'b1; hand_hit = 1'b0; cycle("R12"); hand_en = 1'b0;

    // R3: global ignores ASID
    fill(48'h0000_0040_0000, 16'h0001, 8'h01, 1'b1, 44'h000_0777_7000, 8'h11, "R3");
    look(48'h0000_0040_0123, 16'hbeef, 8'h01, 1'b1, "R3");

    // R2/R5: 64KB granule
    cfg_gran64 = 1'b1;
    fill(48'h0000_0ab3_0000, 16'h0009, 8'h03, 1'b0, 44'h000_1234_5000, 8'h22, "R5");
    look(48'h0000_0ab3_7123, 16'h0009, 8'h03, 1'b1, "R5");
    look(48'h0000_0ab4_0000, 16'h0009, 8'h03, 1'b0, "R2");
    cfg_gran64 = 1'b0;
    look(48'h0000_0ab3_0123, 16'h0009, 8'h03, 1'b0, "R2");

    // R8: duplicate tags, lower slot wins
    fill(48'h0000_5555_0000, 16'h0002, 8'h04, 1'b0, 44'h000_aaaa_a000, 8'h31, "R8");
    fill(48'h0000_5555_0000, 16'h0002, 8'h04, 1'b0, 44'h000_bbbb_b000, 8'h32, "R8");
    look(48'h0000_5555_0fff, 16'h0002, 8'h04, 1'b1, "R8");

    // R11: invalidate blocks a fill and a same-cycle lookup sees old state
    lk_valid = 1'b1; lk_va = 48'h0000_5555_0010; lk_asid = 16'h0002; lk_vmid = 8'h04;
    fill_valid = 1'b1; fill_va = 48'h0000_6666_0000; fill_asid = 16'h0002; fill_vmid = 8'h04;
    fill_global = 1'b0; fill_pa = 44'h000_cccc_c000; fill_attr = 8'h40;
    inv_valid = 1'b1; inv_op = 2'd3;
    hand_en = 1'b1; hand_hit = 1'b1;
    cycle("R11");
    hand_en = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0; lk_valid = 1'b0;
    look(48'h0000_6666_0000, 16'h0002, 8'h04, 1'b0, "R11");
    // R10: code 3 changed nothing
    look(48'h0000_5555_0000, 16'h0002, 8'h04, 1'b1, "R10");

    // R10: by ASID keeps global slots
    inval(2'd1, 16'h0001, 8'h00, "R10");
    look(48'h0000_0040_0000, 16'h0001, 8'h01, 1'b1, "R10");
    inval(2'd1, 16'h0105, 8'h00, "R10");
    look(48'h1234_5678_9000, 16'h0105, 8'h01, 1'b0, "R10");
    look(48'h0000_5555_0000, 16'h0002, 8'h04, 1'b1, "R10");
    // R10: by VMID
    inval(2'd2, 16'h0000, 8'h04, "R10");
    look(48'h0000_5555_0000, 16'h0002, 8'h04, 1'b0, "R10");
    look(48'h0000_0040_0000, 16'h0001, 8'h01, 1'b1, "R10");
    // R9: clear everything
    inval(2'd0, 16'h0000, 8'h00, "R9");
    look(48'h0000_0040_0000, 16'h0001, 8'h01, 1'b0, "R9");

    // R6: fill to full, free one slot, refill it without evictions
    for (int k = 1; k < N; k++)
      fill({24'h0, 12'(k), 12'h000}, 16'h0000, 8'h07, 1'b1, {20'h0, 12'(k), 12'h000}, 8'(k), "R6");
    fill(48'h0000_0010_0000, 16'h0000, 8'h09, 1'b1, 44'h000_0099_9000, 8'h99, "R6");
    inval(2'd2, 16'h0000, 8'h09, "R6");
    fill({24'h0, 12'd40, 12'h000}, 16'h0000, 8'h07, 1'b1, {20'h0, 12'd40, 12'h000}, 8'd40, "R6");
    for (int k = 1; k < N; k++) look({24'h0, 12'(k), 12'h000}, 16'h0000, 8'h07, 1'b1, "R6");
    look({24'h0, 12'd40, 12'h000}, 16'h0000, 8'h07, 1'b1, "R6");

    // R7: full cache replaces along the round-robin pointer
    for (int k = 41; k < 44; k++)
      fill({24'h0, 12'(k), 12'h000}, 16'h0000, 8'h07, 1'b1, {20'h0, 12'(k), 12'h000}, 8'(k), "R7");
    for (int k = 41; k < 44; k++) look({24'h0, 12'(k), 12'h000}, 16'h0000, 8'h07, 1'b1, "R7");
    hand_en = 1'b0;
    for (int k = 1; k < N; k++) begin
      lk_valid = 1'b1; lk_va = {24'h0, 12'(k), 12'h000}; lk_asid = 16'h0; lk_vmid = 8'h07;
      cycle("R7");
    end
    lk_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule